// File: doc/BRIEF.md
# Quarter-Pel Luma Interpolation Unit

This unit builds one motion-compensated luma prediction block from a reference plane. A start pulse supplies the block position, the block shape and a signed motion vector in quarter-sample units. The unit splits each vector component into an integer displacement and a two-bit fractional phase. It then fetches a window of reference samples into local storage through a synchronous read port. Any coordinate that falls outside the plane is clamped to the nearest edge row or column before the read.

Once the window is loaded, the unit computes one prediction sample per accepted beat and streams the samples in raster order over a valid/ready interface. The arithmetic covers four cases: the six-tap half-sample filter, the two-stage centre sample built from unrounded horizontal sums, the rounding averages for the twelve quarter-sample phases, and the plain copy for the integer phase. After the last sample is taken, `done` pulses once.

The read port has one cycle of latency: the sample for the coordinate presented with `rd_en` must appear on `rd_data` on the following cycle.

Top module: `qpel_luma_interp`

## Requirements
- R1: Each vector component splits into an integer displacement and a fractional phase. The displacement is the component shifted right arithmetically by two, so negative vectors round toward minus infinity. The phase is the component's two low bits.
- R2: Phase (2,0) outputs the horizontal half sample and phase (0,2) outputs the vertical half sample. Each is the tap sum with weights 1,-5,20,20,-5,1 over positions -2..+3, then (sum+16)>>5, clipped to 0..255.
- R3: Phase (2,2) applies the same tap weights vertically to the unrounded horizontal sums of rows -2..+3, then computes (sum+512)>>10 and clips to 0..255.
- R4: Phase (0,0) outputs the reference sample at the integer position unchanged.
- R5: The single-axis quarter phases each average a half sample with an integer sample. (1,0) uses the horizontal half sample and the integer sample at x. (3,0) uses the horizontal half sample and the integer sample at x+1. (0,1) uses the vertical half sample and the integer sample at y. (0,3) uses the vertical half sample and the integer sample at y+1. Every average is (a+b+1)>>1.
- R6: The diagonal phases average one horizontal and one vertical half sample. (1,1) uses row 0 and column 0. (3,1) uses row 0 and column +1. (1,3) uses column 0 and row +1. (3,3) uses column +1 and row +1.
- R7: The phases that border the centre average the centre sample with one half sample. (2,1) uses the horizontal half sample at row 0 and (2,3) uses the one at row +1. (1,2) uses the vertical half sample at column 0 and (3,2) uses the one at column +1.
- R8: Every reference coordinate is clamped into the plane before it is read, so `rd_x` < FRAME_W and `rd_y` < FRAME_H at all times. Samples beyond an edge take the value of the edge sample.
- R9: `wide`=1 selects 16 columns and `wide`=0 selects 8; `tall` selects 16 or 8 rows the same way. Exactly width×height samples are emitted in raster order. `done` is high for exactly one cycle, in the cycle after the final sample is accepted.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pix` hold their values.
- R11: A start pulse that arrives while a block is in progress is ignored and does not alter that block's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block (taken only when idle) |
| blk_x | input | $clog2(FRAME_W) | Block left column |
| blk_y | input | $clog2(FRAME_H) | Block top row |
| wide | input | 1 | 1: 16 columns, 0: 8 columns |
| tall | input | 1 | 1: 16 rows, 0: 8 rows |
| mv_x | input | MVW | Signed horizontal vector, quarter samples |
| mv_y | input | MVW | Signed vertical vector, quarter samples |
| rd_en | output | 1 | Reference read request |
| rd_x | output | $clog2(FRAME_W) | Clamped read column |
| rd_y | output | $clog2(FRAME_H) | Clamped read row |
| rd_data | input | 8 | Read sample, one cycle after rd_en |
| out_valid | output | 1 | Prediction sample valid |
| out_ready | input | 1 | Consumer accepts sample |
| out_pix | output | 8 | Prediction sample |
| done | output | 1 | One-cycle pulse after the last accepted sample |

## Verification
The assertions check properties that must hold on every cycle regardless of the arithmetic. A sample that is valid but not accepted must stay frozen. `done` must be a single-cycle pulse, and it must follow exactly width×height handshakes. Read coordinates must stay inside the frame, the latched block parameters must not change when a start arrives mid-block, and no output may be valid while the window is being fetched.

The correctness of the values themselves can only be shown by the bench's scenarios, which compare every emitted sample against an independent model. Those scenarios cover each of the sixteen phase formulas, the rounding and clipping, the negative-vector split, edge clamping at the frame corners, and the ignored start.

// File: rtl/qpel_pkg.sv
package qpel_pkg;

  localparam int ACC_W = 22;
  localparam int MID_W = 16;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic signed [MID_W-1:0] mid_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SETTLE, ST_EMIT} state_e;

  localparam acc_t K5    = 5;
  localparam acc_t K20   = 20;
  localparam acc_t RND5  = 16;
  localparam acc_t RND10 = 512;
  localparam acc_t PMAX  = 255;

  // six-tap weighted sum, full precision
  function automatic acc_t tap6(input acc_t a, input acc_t b, input acc_t c,
                                input acc_t d, input acc_t e, input acc_t f);
    return a - K5 * b + K20 * (c + d) - K5 * e + f;
  endfunction

  function automatic acc_t pix_ext(input logic [7:0] p);
    acc_t r;
    r = '0;
    r[7:0] = p;
    return r;
  endfunction

  function automatic acc_t mid_ext(input mid_t m);
    return acc_t'(m);
  endfunction

  function automatic logic [7:0] clip8(input acc_t v);
    if (v[ACC_W-1]) return 8'd0;
    else if (v > PMAX) return 8'd255;
    else return v[7:0];
  endfunction

  function automatic logic [7:0] round_half(input acc_t s);
    return clip8((s + RND5) >>> 5);
  endfunction

  function automatic logic [7:0] round_ctr(input acc_t s);
    return clip8((s + RND10) >>> 10);
  endfunction

  function automatic logic [7:0] avg2(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b} + 9'd1;
    return t[8:1];
  endfunction

endpackage

// File: rtl/qpel_fetch.sv
module qpel_fetch #(
  parameter int FRAME_W = 64,
  parameter int FRAME_H = 48,
  parameter int WS      = 21,
  parameter int CW      = 18,
  parameter int XW      = 6,
  parameter int YW      = 6,
  parameter int IW      = 9,
  parameter int RW      = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 go,
  input  logic signed [CW-1:0] org_x,
  input  logic signed [CW-1:0] org_y,
  input  logic [RW-1:0]        col_max,
  input  logic [RW-1:0]        row_max,
  output logic                 rd_en,
  output logic [XW-1:0]        rd_x,
  output logic [YW-1:0]        rd_y,
  output logic                 wr_en,
  output logic [IW-1:0]        wr_idx,
  output logic                 last
);

  localparam logic signed [CW-1:0] XMAX = CW'(FRAME_W - 1);
  localparam logic signed [CW-1:0] YMAX = CW'(FRAME_H - 1);

  logic [RW-1:0] col_q, col_d, row_q, row_d;
  logic          wr_en_q;
  logic [IW-1:0] wr_idx_q;
  logic signed [CW-1:0] sx, sy;

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    if (load) begin
      col_d = '0;
      row_d = '0;
    end else if (go) begin
      if (col_q == col_max) begin
        col_d = '0;
        row_d = row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (load || go) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  // coordinate clamping toward the nearest valid edge
  always_comb begin
    sx = org_x + $signed({{(CW-RW){1'b0}}, col_q});
    sy = org_y + $signed({{(CW-RW){1'b0}}, row_q});
    if (sx[CW-1])      rd_x = '0;
    else if (sx > XMAX) rd_x = XMAX[XW-1:0];
    else               rd_x = sx[XW-1:0];
    if (sy[CW-1])      rd_y = '0;
    else if (sy > YMAX) rd_y = YMAX[YW-1:0];
    else               rd_y = sy[YW-1:0];
  end

  assign rd_en = go;
  assign last  = go && (col_q == col_max) && (row_q == row_max);

  // returned data lands one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q  <= 1'b0;
      wr_idx_q <= '0;
    end else begin
      wr_en_q  <= go;
      wr_idx_q <= IW'(row_q) * IW'(WS) + IW'(col_q);
    end
  end

  assign wr_en  = wr_en_q;
  assign wr_idx = wr_idx_q;

  a_r8_rd_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (32'(rd_y) < FRAME_H) && (32'(rd_x) < FRAME_W));

endmodule

// File: rtl/qpel_window.sv
module qpel_window #(
  parameter int WIN_N = 441,
  parameter int IW    = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  output logic [7:0]    win_q [WIN_N]
);

  always_ff @(posedge clk) begin
    if (wr_en) win_q[wr_idx] <= wr_data;
  end

endmodule

// File: rtl/qpel_filter.sv
module qpel_filter
  import qpel_pkg::*;
#(
  parameter int WS    = 21,
  parameter int WIN_N = 441,
  parameter int IW    = 9,
  parameter int BW    = 4
) (
  input  logic [7:0]    win [WIN_N],
  input  logic [BW-1:0] row_i,
  input  logic [BW-1:0] col_i,
  input  logic [1:0]    fx,
  input  logic [1:0]    fy,
  output logic [7:0]    pix
);

  function automatic logic [IW-1:0] wix(input logic [IW-1:0] r, input logic [IW-1:0] c);
    return r * IW'(WS) + c;
  endfunction

  logic [IW-1:0] r0, c0;
  mid_t hs [6];
  acc_t tin [6];
  acc_t vs [2];
  logic [7:0] b0, b1, h0, h1, jc, g, gx, gy;

  assign r0 = IW'(row_i);
  assign c0 = IW'(col_i);

  // window row r0+k is reference row -2+k; column c0+t is column -2+t
  always_comb begin
    for (int k = 0; k < 6; k++) begin
      for (int t = 0; t < 6; t++)
        tin[t] = pix_ext(win[wix(r0 + IW'(k), c0 + IW'(t))]);
      hs[k] = mid_t'(tap6(tin[0], tin[1], tin[2], tin[3], tin[4], tin[5]));
    end
    for (int d = 0; d < 2; d++) begin
      for (int t = 0; t < 6; t++)
        tin[t] = pix_ext(win[wix(r0 + IW'(t), c0 + IW'(2 + d))]);
      vs[d] = tap6(tin[0], tin[1], tin[2], tin[3], tin[4], tin[5]);
    end
    b0 = round_half(mid_ext(hs[2]));
    b1 = round_half(mid_ext(hs[3]));
    h0 = round_half(vs[0]);
    h1 = round_half(vs[1]);
    jc = round_ctr(tap6(mid_ext(hs[0]), mid_ext(hs[1]), mid_ext(hs[2]),
                        mid_ext(hs[3]), mid_ext(hs[4]), mid_ext(hs[5])));
    g  = win[wix(r0 + IW'(2), c0 + IW'(2))];
    gx = win[wix(r0 + IW'(2), c0 + IW'(3))];
    gy = win[wix(r0 + IW'(3), c0 + IW'(2))];
  end

  always_comb begin
    case ({fx, fy})
      4'h0: pix = g;
      4'h4: pix = avg2(g, b0);
      4'h8: pix = b0;
      4'hC: pix = avg2(gx, b0);
      4'h1: pix = avg2(g, h0);
      4'h2: pix = h0;
      4'h3: pix = avg2(gy, h0);
      4'h5: pix = avg2(b0, h0);
      4'h9: pix = avg2(b0, jc);
      4'hD: pix = avg2(b0, h1);
      4'h6: pix = avg2(h0, jc);
      4'hA: pix = jc;
      4'hE: pix = avg2(jc, h1);
      4'h7: pix = avg2(h0, b1);
      4'hB: pix = avg2(jc, b1);
      default: pix = avg2(h1, b1);
    endcase
  end

endmodule

// File: rtl/qpel_luma_interp.sv
module qpel_luma_interp
  import qpel_pkg::*;
#(
  parameter int FRAME_W = 64,
  parameter int FRAME_H = 48,
  parameter int MVW     = 16,
  parameter int BIG     = 16,
  parameter int SMALL   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [$clog2(FRAME_W)-1:0]     blk_x,
  input  logic [$clog2(FRAME_H)-1:0]     blk_y,
  input  logic                           wide,
  input  logic                           tall,
  input  logic signed [MVW-1:0]          mv_x,
  input  logic signed [MVW-1:0]          mv_y,
  output logic                           rd_en,
  output logic [$clog2(FRAME_W)-1:0]     rd_x,
  output logic [$clog2(FRAME_H)-1:0]     rd_y,
  input  logic [7:0]                     rd_data,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [7:0]                     out_pix,
  output logic                           done
);

  localparam int PAD   = 5;
  localparam int WS    = BIG + PAD;
  localparam int WIN_N = WS * WS;
  localparam int IW    = $clog2(WIN_N);
  localparam int RW    = $clog2(WS);
  localparam int BW    = $clog2(BIG);
  localparam int XW    = $clog2(FRAME_W);
  localparam int YW    = $clog2(FRAME_H);
  localparam int CW    = ((XW > MVW) ? XW : MVW) + 2;
  localparam int NW    = $clog2(BIG * BIG) + 1;

  // asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  state_e st_q, st_d;
  logic [1:0] fx_q, fx_d, fy_q, fy_d;
  logic wide_q, wide_d, tall_q, tall_d;
  logic signed [CW-1:0] ox_q, ox_d, oy_q, oy_d;
  logic [BW-1:0] xl_q, xl_d, yl_q, yl_d;
  logic more_q, more_d, ov_q, ov_d, done_q, done_d;
  logic [7:0] pix_q, pix_d, filt_pix;
  logic [RW-1:0] col_max, row_max;
  logic [BW-1:0] x_last, y_last;
  logic load, go, f_last, wr_en, load_px, at_end;
  logic [IW-1:0] wr_idx;
  logic [7:0] win [WIN_N];

  assign load    = (st_q == ST_IDLE) && start;
  assign go      = (st_q == ST_FETCH);
  assign col_max = wide_q ? RW'(BIG + PAD - 1) : RW'(SMALL + PAD - 1);
  assign row_max = tall_q ? RW'(BIG + PAD - 1) : RW'(SMALL + PAD - 1);
  assign x_last  = wide_q ? BW'(BIG - 1) : BW'(SMALL - 1);
  assign y_last  = tall_q ? BW'(BIG - 1) : BW'(SMALL - 1);
  assign at_end  = (xl_q == x_last) && (yl_q == y_last);
  assign load_px = (st_q == ST_EMIT) && more_q && (!ov_q || out_ready);

  qpel_fetch #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .WS(WS), .CW(CW),
               .XW(XW), .YW(YW), .IW(IW), .RW(RW)) fetch_i (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .go(go),
    .org_x(ox_q), .org_y(oy_q), .col_max(col_max), .row_max(row_max),
    .rd_en(rd_en), .rd_x(rd_x), .rd_y(rd_y),
    .wr_en(wr_en), .wr_idx(wr_idx), .last(f_last));

  qpel_window #(.WIN_N(WIN_N), .IW(IW)) window_i (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(rd_data), .win_q(win));

  qpel_filter #(.WS(WS), .WIN_N(WIN_N), .IW(IW), .BW(BW)) filter_i (
    .win(win), .row_i(yl_q), .col_i(xl_q), .fx(fx_q), .fy(fy_q), .pix(filt_pix));

  always_comb begin
    st_d   = st_q;
    fx_d   = fx_q;
    fy_d   = fy_q;
    wide_d = wide_q;
    tall_d = tall_q;
    ox_d   = ox_q;
    oy_d   = oy_q;
    xl_d   = xl_q;
    yl_d   = yl_q;
    more_d = more_q;
    ov_d   = ov_q;
    pix_d  = pix_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_FETCH;
        fx_d   = mv_x[1:0];
        fy_d   = mv_y[1:0];
        wide_d = wide;
        tall_d = tall;
        ox_d   = $signed({{(CW-XW){1'b0}}, blk_x}) + CW'(mv_x >>> 2) - CW'(2);
        oy_d   = $signed({{(CW-YW){1'b0}}, blk_y}) + CW'(mv_y >>> 2) - CW'(2);
      end
      ST_FETCH: if (f_last) st_d = ST_SETTLE;
      ST_SETTLE: begin
        st_d   = ST_EMIT;
        more_d = 1'b1;
        xl_d   = '0;
        yl_d   = '0;
      end
      default: begin
        if (load_px) begin
          pix_d = filt_pix;
          ov_d  = 1'b1;
          if (at_end) begin
            more_d = 1'b0;
          end else if (xl_q == x_last) begin
            xl_d = '0;
            yl_d = yl_q + 1'b1;
          end else begin
            xl_d = xl_q + 1'b1;
          end
        end else if (ov_q && out_ready) begin
          ov_d = 1'b0;
          if (!more_q) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      fx_q   <= '0;
      fy_q   <= '0;
      wide_q <= 1'b0;
      tall_q <= 1'b0;
      ox_q   <= '0;
      oy_q   <= '0;
      xl_q   <= '0;
      yl_q   <= '0;
      more_q <= 1'b0;
      ov_q   <= 1'b0;
      pix_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fx_q   <= fx_d;
      fy_q   <= fy_d;
      wide_q <= wide_d;
      tall_q <= tall_d;
      ox_q   <= ox_d;
      oy_q   <= oy_d;
      xl_q   <= xl_d;
      yl_q   <= yl_d;
      more_q <= more_d;
      ov_q   <= ov_d;
      pix_q  <= pix_d;
      done_q <= done_d;
    end
  end

  assign out_valid = ov_q;
  assign out_pix   = pix_q;
  assign done      = done_q;

  // handshake tally used only by the checks below
  logic [NW-1:0] hs_cnt_q, hs_exp;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)              hs_cnt_q <= '0;
    else if (load)                hs_cnt_q <= '0;
    else if (out_valid && out_ready) hs_cnt_q <= hs_cnt_q + 1'b1;
  end
  assign hs_exp = NW'((wide_q ? BIG : SMALL) * (tall_q ? BIG : SMALL));

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  a_r9_pixel_count: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (hs_cnt_q == hs_exp));

  a_r9_quiet_fetch: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en |-> !out_valid);

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && (st_q != ST_IDLE)) |=> ($stable(ox_q) && $stable(oy_q) &&
                                      $stable(fx_q) && $stable(fy_q) &&
                                      $stable(wide_q) && $stable(tall_q)));

endmodule

// File: tb/qpel_luma_interp_tb_top.sv
`timescale 1ns/1ps
module qpel_luma_interp_tb_top;

  localparam int FW = 64;
  localparam int FH = 48;

  logic clk, rst_n, start, wide, tall, rd_en, out_valid, out_ready, done;
  logic [5:0] blk_x, rd_x;
  logic [5:0] blk_y, rd_y;
  logic signed [15:0] mv_x, mv_y;
  logic [7:0] rd_data, out_pix;
  logic [7:0] plane [FH][FW];

  int n_chk = 0;
  int n_fail = 0;

  qpel_luma_interp dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_x(blk_x), .blk_y(blk_y),
    .wide(wide), .tall(tall), .mv_x(mv_x), .mv_y(mv_y),
    .rd_en(rd_en), .rd_x(rd_x), .rd_y(rd_y), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .done(done));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference memory, one cycle of read latency
  always @(posedge clk) if (rd_en) rd_data <= plane[rd_y][rd_x];

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v,
                     input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp_v);
    end
  endtask

  // R8: read coordinates never leave the frame
  always @(negedge clk) if (rst_n && rd_en)
    chk((rd_x < FW) && (rd_y < FH), "R8", int'(rd_y), FH - 1, "read row in frame");

  function automatic int smp(int x, int y);
    int xc = (x < 0) ? 0 : ((x > FW - 1) ? FW - 1 : x);
    int yc = (y < 0) ? 0 : ((y > FH - 1) ? FH - 1 : y);
    return int'(plane[yc][xc]);
  endfunction

  function automatic int f6(int a, int b, int c, int d, int e, int f);
    return a - 5 * b + 20 * c + 20 * d - 5 * e + f;
  endfunction

  function automatic int clp(int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  function automatic int hraw(int x, int y);
    return f6(smp(x-2,y), smp(x-1,y), smp(x,y), smp(x+1,y), smp(x+2,y), smp(x+3,y));
  endfunction

  function automatic int hh(int x, int y);
    return clp((hraw(x, y) + 16) >>> 5);
  endfunction

  function automatic int vv(int x, int y);
    return clp((f6(smp(x,y-2), smp(x,y-1), smp(x,y), smp(x,y+1), smp(x,y+2), smp(x,y+3))
                + 16) >>> 5);
  endfunction

  function automatic int cc(int x, int y);
    return clp((f6(hraw(x,y-2), hraw(x,y-1), hraw(x,y), hraw(x,y+1), hraw(x,y+2),
                   hraw(x,y+3)) + 512) >>> 10);
  endfunction

  function automatic int av(int a, int b);
    return (a + b + 1) >>> 1;
  endfunction

  function automatic int ref_pix(int bx, int by, int mvx, int mvy, int xl, int yl);
    int x = bx + (mvx >>> 2) + xl;
    int y = by + (mvy >>> 2) + yl;
    int fx = mvx & 3;
    int fy = mvy & 3;
    case (fx * 4 + fy)
      0:  return smp(x, y);
      4:  return av(smp(x, y), hh(x, y));
      8:  return hh(x, y);
      12: return av(smp(x + 1, y), hh(x, y));
      1:  return av(smp(x, y), vv(x, y));
      2:  return vv(x, y);
      3:  return av(smp(x, y + 1), vv(x, y));
      5:  return av(hh(x, y), vv(x, y));
      9:  return av(hh(x, y), cc(x, y));
      13: return av(hh(x, y), vv(x + 1, y));
      6:  return av(vv(x, y), cc(x, y));
      10: return cc(x, y);
      14: return av(cc(x, y), vv(x + 1, y));
      7:  return av(vv(x, y), hh(x, y + 1));
      11: return av(cc(x, y), hh(x, y + 1));
      default: return av(vv(x + 1, y), hh(x, y + 1));
    endcase
  endfunction

  function automatic string phase_tag(int mvx, int mvy);
    int fx = mvx & 3;
    int fy = mvy & 3;
    if (fx == 0 && fy == 0) return "R4";
    if ((fx == 2 && fy == 0) || (fx == 0 && fy == 2)) return "R2";
    if (fx == 2 && fy == 2) return "R3";
    if (fx == 0 || fy == 0) return "R5";
    if (fx == 2 || fy == 2) return "R7";
    return "R6";
  endfunction

  task automatic run_block(input int bx, input int by, input bit wd, input bit tl,
                           input int mvx, input int mvy, input string tag,
                           input int rdy_pct, input bit poke);
    int w = wd ? 16 : 8;
    int h = tl ? 16 : 8;
    int n = 0;
    int cyc = 0;
    bit held = 1'b0;
    logic [7:0] held_pix = 8'd0;
    @(negedge clk);
    start = 1'b1; blk_x = 6'(bx); blk_y = 6'(by); wide = wd; tall = tl;
    mv_x = 16'(mvx); mv_y = 16'(mvy);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; blk_x = 6'((bx + 5) % FW); mv_x = 16'(mvx + 6); mv_y = 16'(mvy - 3);
      wide = ~wd;
      @(negedge clk);
      start = 1'b0;
    end
    while (n < w * h && cyc < 6000) begin
      if (held)
        chk(out_valid && (out_pix == held_pix), "R10", int'(out_pix), int'(held_pix),
            "stalled sample held");
      out_ready = (($urandom % 100) < rdy_pct);
      if (out_valid && out_ready) begin
        chk(int'(out_pix) == ref_pix(bx, by, mvx, mvy, n % w, n / w), tag,
            int'(out_pix), ref_pix(bx, by, mvx, mvy, n % w, n / w), "prediction sample");
        n++;
      end
      held = out_valid && !out_ready;
      held_pix = out_pix;
      @(negedge clk);
      cyc++;
    end
    chk(n == w * h, "R9", n, w * h, "samples emitted before timeout");
    out_ready = 1'b0;
    chk(done == 1'b1, "R9", int'(done), 1, "done after last accept");
    @(negedge clk);
    chk(done == 1'b0 && out_valid == 1'b0, "R9", int'(done), 0, "done single cycle");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed = 32'h51ED;
    void'($urandom(seed));
    for (int y = 0; y < FH; y++)
      for (int x = 0; x < FW; x++)
        plane[y][x] = 8'($urandom);
    // saturated corners stress clipping
    for (int x = 20; x < 28; x++) begin
      plane[10][x] = 8'd255; plane[11][x] = 8'd0;
    end
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0; wide = 1'b0; tall = 1'b0;
    blk_x = '0; blk_y = '0; mv_x = '0; mv_y = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0 && rd_en == 1'b0, "R9",
        int'(out_valid), 0, "idle after reset");

    // every phase, rotating through the four shapes
    for (int p = 0; p < 16; p++) begin
      int fx = p / 4;
      int fy = p % 4;
      run_block(16, 16, (p % 2) == 0, (p % 3) != 1, 8 + fx, 4 + fy,
                phase_tag(fx, fy), 70, 1'b0);
    end
    // clipping region, centre and half phases
    run_block(16, 4, 1'b1, 1'b1, 10, 22, "R3", 100, 1'b0);
    run_block(18, 2, 1'b1, 1'b1, 2, 32, "R2", 100, 1'b0);
    // negative vectors round toward minus infinity
    run_block(24, 20, 1'b1, 1'b0, -7, -13, "R1", 80, 1'b0);
    run_block(30, 24, 1'b0, 1'b1, -1, -6, "R1", 80, 1'b0);
    // corners of the frame
    run_block(0, 0, 1'b1, 1'b1, -77, -78, "R8", 90, 1'b0);
    run_block(48, 32, 1'b1, 1'b1, 30, 31, "R8", 90, 1'b0);
    run_block(56, 40, 1'b0, 1'b0, 5, 9, "R8", 100, 1'b0);
    // start pulse mid-block
    run_block(12, 14, 1'b1, 1'b0, 6, 7, "R11", 60, 1'b1);
    // random blocks
    for (int i = 0; i < 20; i++) begin
      int mvx = int'($urandom % 193) - 96;
      int mvy = int'($urandom % 193) - 96;
      run_block(int'($urandom % FW), int'($urandom % FH), 1'($urandom), 1'($urandom),
                mvx, mvy, phase_tag(mvx, mvy), 40 + int'($urandom % 61), 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule